// File: doc/BRIEF.md
# Snoopy MOESI Line State Controller

This block tracks the coherence state of every line in one private write-back cache that sits on a shared snooping bus with other caches. Each line is Invalid, Shared, Exclusive, Owned or Modified. A small direct-mapped tag and state store holds a tag and a state per line. The low address bits select the line and the remaining bits form the tag. The data array, memory and arbitration stay outside the block and are modelled as handshakes: a grant on the bus completes a bus transaction, including any fill.

Processor reads and writes are looked up against the store. Hits that need no bus traffic complete in the same cycle. Other requests raise a bus request and stall until the grant. A dirty victim (Modified or Owned) first raises a write-back request that must be acknowledged. Snooped transactions from other caches are answered in the cycle they appear. The block reports whether it holds the line and whether it drives the data (flush), and the line state is updated at the next clock edge. With the Owned state, dirty data can be shared without a memory write. With Exclusive fills, a later write needs no bus transaction.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid: a snooped read of any address sees snoop_shared_out low, and neither bus_req_valid nor wb_req_valid is asserted.
- R2: A read miss issues a bus request with op code 01 (read). If bus_shared_in is low at the grant, the line is filled as Exclusive.
- R3: A read miss granted with bus_shared_in high fills the line as Shared.
- R4: A processor write to a Modified line completes in the request cycle with no bus request, and the line stays Modified.
- R5: A processor write to an Exclusive line completes in the request cycle with no bus request, and the line becomes Modified.
- R6: A processor write to a Shared or Owned line issues op code 11 (upgrade), holds the request and keeps cpu_done low until bus_gnt, and then leaves the line Modified.
- R7: A write miss issues op code 10 (read-exclusive), stalls until bus_gnt, and fills the line as Modified.
- R8: A snooped read (op 01) that hits a Modified or Owned line asserts snoop_flush and leaves the line Owned.
- R9: A snooped read that hits an Exclusive or Shared line does not assert snoop_flush, so memory supplies the data. An Exclusive line becomes Shared.
- R10: A snooped read-exclusive (op 10) or upgrade (op 11) that hits a valid line makes it Invalid. It asserts snoop_flush first if the line was Modified or Owned.
- R11: snoop_shared_out is high during a snoop exactly when the snooped address matches a line held in any valid state.
- R12: A miss whose victim is Modified or Owned raises wb_req_valid with the victim's address and holds it until wb_ack, before any bus request. An Exclusive or Shared victim is dropped with no write-back.
- R13: A read hit completes in the request cycle with no bus request and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request, held until cpu_done |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Line address: low bits index, high bits tag |
| cpu_done | output | 1 | Request completes this cycle |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_op | output | 2 | 01 read, 10 read-exclusive, 11 upgrade |
| bus_req_addr | output | ADDR_W | Address of the bus transaction |
| bus_gnt | input | 1 | Bus transaction (with any fill) completes |
| bus_shared_in | input | 1 | Another cache holds the line, valid with bus_gnt |
| snoop_valid | input | 1 | Another cache's transaction is on the bus |
| snoop_op | input | 2 | Snooped op, same encoding as bus_req_op |
| snoop_addr | input | ADDR_W | Snooped line address |
| snoop_shared_out | output | 1 | This cache holds the snooped line |
| snoop_flush | output | 1 | This cache supplies the snooped line's data |
| wb_req_valid | output | 1 | Victim write-back requested |
| wb_req_addr | output | ADDR_W | Victim line address |
| wb_ack | input | 1 | Write-back accepted |

## Verification
A wrong line state cannot be read out directly. It shows at the ports the next time the line is touched. A state that is wrongly clean drops snoop_flush or the write-back request on the next snoop or eviction. A state that is wrongly Shared adds an upgrade request to a write that should be silent. A lost state clears snoop_shared_out on the next snoop. Each stimulus is therefore followed, within one or two operations, by a snoop or processor access whose response can only be right if the earlier transition was.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

   typedef enum logic [2:0] {
      ST_I = 3'd0,
      ST_S = 3'd1,
      ST_E = 3'd2,
      ST_O = 3'd3,
      ST_M = 3'd4
   } line_state_e;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_RD   = 2'd1,
      OP_RDX  = 2'd2,
      OP_UPGR = 2'd3
   } bus_op_e;

   function automatic logic is_dirty(input line_state_e s);
      return (s == ST_M) || (s == ST_O);
   endfunction

endpackage

// File: rtl/moesi_tag_store.sv
module moesi_tag_store
   import moesi_pkg::*;
#(
   parameter int LINES = 4,
   parameter int TAG_W = 6,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx_a,
   output logic [TAG_W-1:0] tag_a,
   output line_state_e      state_a,
   input  logic [IDX_W-1:0] rd_idx_b,
   output logic [TAG_W-1:0] tag_b,
   output line_state_e      state_b,
   input  logic             we,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  line_state_e      wr_state
);

   logic [TAG_W-1:0] tag_q [LINES];
   line_state_e      st_q  [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [TAG_W-1:0] tag_r;
      line_state_e      st_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tag_r <= '0;
            st_r  <= ST_I;
         end else if (we && (wr_idx == IDX_W'(g))) begin
            tag_r <= wr_tag;
            st_r  <= wr_state;
         end
      end

      assign tag_q[g] = tag_r;
      assign st_q[g]  = st_r;
   end

   assign tag_a   = tag_q[rd_idx_a];
   assign state_a = st_q[rd_idx_a];
   assign tag_b   = tag_q[rd_idx_b];
   assign state_b = st_q[rd_idx_b];

endmodule

// File: rtl/moesi_snoop_resp.sv
module moesi_snoop_resp
   import moesi_pkg::*;
(
   input  logic        snp_valid,
   input  bus_op_e     snp_op,
   input  logic        tag_match,
   input  line_state_e cur,
   output logic        hit,
   output logic        shared,
   output logic        flush,
   output line_state_e nxt
);

   always_comb begin
      hit    = snp_valid && tag_match && (cur != ST_I);
      shared = hit;
      flush  = 1'b0;
      nxt    = cur;
      if (hit) begin
         unique case (snp_op)
            OP_RD: begin
               flush = is_dirty(cur);
               if (is_dirty(cur))   nxt = ST_O;
               else if (cur == ST_E) nxt = ST_S;
            end
            OP_RDX, OP_UPGR: begin
               flush = is_dirty(cur);
               nxt   = ST_I;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/moesi_cpu_seq.sv
module moesi_cpu_seq
   import moesi_pkg::*;
#(
   parameter int TAG_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [TAG_W-1:0] req_tag,
   input  logic [TAG_W-1:0] line_tag,
   input  line_state_e      line_state,
   input  logic             snoop_busy,
   input  logic             bus_gnt,
   input  logic             bus_shared,
   input  logic             wb_ack,
   output logic             done,
   output logic             bus_req,
   output bus_op_e          bus_op,
   output logic             wb_req,
   output logic             we,
   output line_state_e      wstate
);

   typedef enum logic [1:0] {SEQ_IDLE, SEQ_WB, SEQ_BUS} seq_e;

   seq_e    seq_q, seq_d;
   bus_op_e op_q, op_d;
   logic    hit;

   assign hit = (line_state != ST_I) && (line_tag == req_tag);

   always_comb begin
      seq_d   = seq_q;
      op_d    = op_q;
      done    = 1'b0;
      bus_req = 1'b0;
      wb_req  = 1'b0;
      we      = 1'b0;
      wstate  = line_state;
      unique case (seq_q)
         SEQ_IDLE: begin
            if (req_valid && !snoop_busy) begin
               if (hit && !req_write) begin
                  done = 1'b1;
               end else if (hit && (line_state == ST_M)) begin
                  done = 1'b1;
               end else if (hit && (line_state == ST_E)) begin
                  done   = 1'b1;
                  we     = 1'b1;
                  wstate = ST_M;
               end else if (hit) begin
                  op_d  = OP_UPGR;
                  seq_d = SEQ_BUS;
               end else begin
                  op_d  = req_write ? OP_RDX : OP_RD;
                  seq_d = is_dirty(line_state) ? SEQ_WB : SEQ_BUS;
               end
            end
         end
         SEQ_WB: begin
            wb_req = 1'b1;
            if (wb_ack) seq_d = SEQ_BUS;
         end
         SEQ_BUS: begin
            bus_req = 1'b1;
            if (bus_gnt) begin
               done   = 1'b1;
               we     = 1'b1;
               wstate = (op_q != OP_RD) ? ST_M : (bus_shared ? ST_S : ST_E);
               seq_d  = SEQ_IDLE;
            end
         end
         default: seq_d = SEQ_IDLE;
      endcase
   end

   assign bus_op = bus_req ? op_q : OP_NONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q <= SEQ_IDLE;
         op_q  <= OP_NONE;
      end else begin
         seq_q <= seq_d;
         op_q  <= op_d;
      end
   end

   // R6 R7: a pending bus request is held with a steady op until granted
   a_r6_hold_bus_req: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_gnt |=> bus_req && $stable(bus_op));

   // R12: write-back is held until acknowledged
   a_r12_hold_wb: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req && !wb_ack |=> wb_req);

   // R12: write-back and bus request never overlap
   a_r12_wb_then_bus: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req |-> !bus_req);

   // R13: completion only for a live request
   a_r13_done_has_req: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_valid);

endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
   import moesi_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LINES  = 4,
   localparam int IDX_W = $clog2(LINES),
   localparam int TAG_W = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req_valid,
   input  logic              cpu_req_write,
   input  logic [ADDR_W-1:0] cpu_req_addr,
   output logic              cpu_done,
   output logic              bus_req_valid,
   output logic [1:0]        bus_req_op,
   output logic [ADDR_W-1:0] bus_req_addr,
   input  logic              bus_gnt,
   input  logic              bus_shared_in,
   input  logic              snoop_valid,
   input  logic [1:0]        snoop_op,
   input  logic [ADDR_W-1:0] snoop_addr,
   output logic              snoop_shared_out,
   output logic              snoop_flush,
   output logic              wb_req_valid,
   output logic [ADDR_W-1:0] wb_req_addr,
   input  logic              wb_ack
);

   if (LINES < 2 || (1 << IDX_W) != LINES) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed the index width");
   end

   logic [IDX_W-1:0] cpu_idx, snp_idx;
   logic [TAG_W-1:0] cpu_tag, snp_tag, cpu_line_tag, snp_line_tag;
   line_state_e      cpu_line_st, snp_line_st, snp_nxt, cpu_wstate, wr_state;
   logic             snp_hit, snp_we, cpu_we, wr_en;
   logic [IDX_W-1:0] wr_idx;
   logic [TAG_W-1:0] wr_tag;
   bus_op_e          seq_op;

   assign cpu_idx = cpu_req_addr[IDX_W-1:0];
   assign cpu_tag = cpu_req_addr[ADDR_W-1:IDX_W];
   assign snp_idx = snoop_addr[IDX_W-1:0];
   assign snp_tag = snoop_addr[ADDR_W-1:IDX_W];

   moesi_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) i_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx_a (cpu_idx),
      .tag_a    (cpu_line_tag),
      .state_a  (cpu_line_st),
      .rd_idx_b (snp_idx),
      .tag_b    (snp_line_tag),
      .state_b  (snp_line_st),
      .we       (wr_en),
      .wr_idx   (wr_idx),
      .wr_tag   (wr_tag),
      .wr_state (wr_state)
   );

   moesi_snoop_resp i_snoop (
      .snp_valid (snoop_valid),
      .snp_op    (bus_op_e'(snoop_op)),
      .tag_match (snp_line_tag == snp_tag),
      .cur       (snp_line_st),
      .hit       (snp_hit),
      .shared    (snoop_shared_out),
      .flush     (snoop_flush),
      .nxt       (snp_nxt)
   );

   moesi_cpu_seq #(.TAG_W(TAG_W)) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (cpu_req_valid),
      .req_write  (cpu_req_write),
      .req_tag    (cpu_tag),
      .line_tag   (cpu_line_tag),
      .line_state (cpu_line_st),
      .snoop_busy (snoop_valid),
      .bus_gnt    (bus_gnt),
      .bus_shared (bus_shared_in),
      .wb_ack     (wb_ack),
      .done       (cpu_done),
      .bus_req    (bus_req_valid),
      .bus_op     (seq_op),
      .wb_req     (wb_req_valid),
      .we         (cpu_we),
      .wstate     (cpu_wstate)
   );

   assign bus_req_op   = seq_op;
   assign bus_req_addr = cpu_req_addr;
   assign wb_req_addr  = {cpu_line_tag, cpu_idx};

   // snoop updates take the single write port first
   assign snp_we   = snp_hit && (snp_nxt != snp_line_st);
   assign wr_en    = snp_we || cpu_we;
   assign wr_idx   = snp_we ? snp_idx : cpu_idx;
   assign wr_tag   = snp_we ? snp_line_tag : cpu_tag;
   assign wr_state = snp_we ? snp_nxt : cpu_wstate;

   // the bus carries one transaction at a time: own grant never meets a snoop
   a_r6_bus_serial: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_gnt && snoop_valid));

   // R8 R10: data is only supplied by a cache that holds the line
   a_r8_flush_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
      snoop_flush |-> snoop_shared_out);

   // R11: the shared response only appears during a snoop
   a_r11_shared_in_snoop: assert property (@(posedge clk) disable iff (!rst_n)
      snoop_shared_out |-> snoop_valid);

   // R12: the write-back address stays fixed while pending
   a_r12_wb_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req_valid && !wb_ack |=> $stable(wb_req_addr));

endmodule

// File: tb/test_moesi_line_ctrl.sv
module test_moesi_line_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
   logic [7:0] cpu_req_addr = '0;
   logic       cpu_done;
   logic       bus_req_valid;
   logic [1:0] bus_req_op;
   logic [7:0] bus_req_addr;
   logic       bus_gnt = 1'b0, bus_shared_in = 1'b0;
   logic       snoop_valid = 1'b0;
   logic [1:0] snoop_op = '0;
   logic [7:0] snoop_addr = '0;
   logic       snoop_shared_out, snoop_flush;
   logic       wb_req_valid;
   logic [7:0] wb_req_addr;
   logic       wb_ack = 1'b0;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   moesi_line_ctrl #(.ADDR_W(8), .LINES(4)) i_moesi_line_ctrl (.*);

   typedef struct packed {
      logic [1:0] kind;      // 0 cpu read, 1 cpu write, 2 snoop
      logic [1:0] sop;       // snoop op
      logic [7:0] addr;
      logic       shr;       // bus_shared_in at grant
      logic       exp_wb;
      logic [7:0] exp_wbaddr;
      logic [1:0] exp_op;    // 0 none, 1 read, 2 read-excl, 3 upgrade
      logic       exp_shared;
      logic       exp_flush;
   } vec_t;

   localparam int NV = 26;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 2'd0, 8'h10, 1'b0, 1'b0, 8'h00, 2'd1, 1'b0, 1'b0}, // R2 fill E
      '{2'd2, 2'd1, 8'h14, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0, 1'b0}, // R11 tag miss
      '{2'd1, 2'd0, 8'h10, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0, 1'b0}, // R5 E->M silent
      '{2'd1, 2'd0, 8'h10, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0, 1'b0}, // R4 M stays
      '{2'd2, 2'd1, 8'h10, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 1'b1}, // R8 M->O flush
      '{2'd2, 2'd1, 8'h10, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 1'b1}, // R8 O flush
      '{2'd0, 2'd0, 8'h10, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0, 1'b0}, // R13 read hit
      '{2'd1, 2'd0, 8'h10, 1'b0, 1'b0, 8'h00, 2'd3, 1'b0, 1'b0}, // R6 O upgrade
      '{2'd2, 2'd1, 8'h10, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 1'b1}, // R6 now M
      '{2'd0, 2'd0, 8'h20, 1'b1, 1'b1, 8'h10, 2'd1, 1'b0, 1'b0}, // R12 O victim
      '{2'd2, 2'd1, 8'h20, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 1'b0}, // R3 R9 S
      '{2'd1, 2'd0, 8'h20, 1'b0, 1'b0, 8'h00, 2'd3, 1'b0, 1'b0}, // R6 S upgrade
      '{2'd2, 2'd2, 8'h20, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 1'b1}, // R10 rdx on M
      '{2'd2, 2'd1, 8'h20, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0, 1'b0}, // R10 now I
      '{2'd1, 2'd0, 8'h31, 1'b0, 1'b0, 8'h00, 2'd2, 1'b0, 1'b0}, // R7 write miss
      '{2'd2, 2'd3, 8'h31, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 1'b1}, // R10 upgr on M
      '{2'd0, 2'd0, 8'h42, 1'b0, 1'b0, 8'h00, 2'd1, 1'b0, 1'b0}, // R2 fill E
      '{2'd2, 2'd1, 8'h42, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 1'b0}, // R9 E->S
      '{2'd1, 2'd0, 8'h42, 1'b0, 1'b0, 8'h00, 2'd3, 1'b0, 1'b0}, // R9 proves S
      '{2'd0, 2'd0, 8'h03, 1'b1, 1'b0, 8'h00, 2'd1, 1'b0, 1'b0}, // R3 fill S
      '{2'd0, 2'd0, 8'h07, 1'b0, 1'b0, 8'h00, 2'd1, 1'b0, 1'b0}, // R12 S silent
      '{2'd2, 2'd3, 8'h07, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 1'b0}, // R10 upgr on E
      '{2'd2, 2'd1, 8'h07, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0, 1'b0}, // R11 invalid
      '{2'd0, 2'd0, 8'h42, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0, 1'b0}, // R13 hit M
      '{2'd2, 2'd1, 8'h42, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 1'b1}, // R8 M->O
      '{2'd1, 2'd0, 8'h52, 1'b0, 1'b1, 8'h42, 2'd2, 1'b0, 1'b0}  // R12 R7
   };

   logic       got_wb, early, timeout;
   logic [7:0] got_wbaddr;
   logic [1:0] got_op;
   logic       got_shared, got_flush;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic run_cpu(input logic wr, input logic [7:0] a, input logic shr);
      int waited;
      waited  = 0;
      got_wb  = 1'b0;
      got_op  = 2'd0;
      early   = 1'b0;
      timeout = 1'b1;
      got_wbaddr = '0;
      @(negedge clk);
      cpu_req_valid = 1'b1;
      cpu_req_write = wr;
      cpu_req_addr  = a;
      for (int c = 0; c < 40; c++) begin
         #1;
         if (cpu_done) begin
            if (bus_req_valid) early = 1'b1;
            timeout = 1'b0;
            break;
         end
         if (wb_req_valid) begin
            got_wb = 1'b1;
            got_wbaddr = wb_req_addr;
            wb_ack = 1'b1;
         end
         if (bus_req_valid) begin
            got_op = bus_req_op;
            if (waited >= 2) begin
               bus_gnt = 1'b1;
               bus_shared_in = shr;
            end
            waited++;
         end
         @(negedge clk);
         wb_ack  = 1'b0;
         bus_gnt = 1'b0;
         bus_shared_in = 1'b0;
      end
      @(negedge clk);
      cpu_req_valid = 1'b0;
   endtask

   task automatic run_snoop(input logic [1:0] op, input logic [7:0] a);
      @(negedge clk);
      snoop_valid = 1'b1;
      snoop_op    = op;
      snoop_addr  = a;
      #1;
      got_shared = snoop_shared_out;
      got_flush  = snoop_flush;
      @(negedge clk);
      snoop_valid = 1'b0;
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, no line valid and no requests
      #1;
      chk("R1 bus_req_valid", int'(bus_req_valid), 0);
      chk("R1 wb_req_valid", int'(wb_req_valid), 0);
      for (int i = 0; i < 4; i++) begin
         run_snoop(2'd1, 8'(i));
         chk("R1 shared after reset", int'(got_shared), 0);
      end

      foreach (VECS[i]) begin
         if (VECS[i].kind == 2'd2) begin
            run_snoop(VECS[i].sop, VECS[i].addr);
            chk($sformatf("R11 vec%0d shared", i), int'(got_shared), int'(VECS[i].exp_shared));
            chk($sformatf("R8 R9 R10 vec%0d flush", i), int'(got_flush), int'(VECS[i].exp_flush));
         end else begin
            run_cpu(VECS[i].kind[0], VECS[i].addr, VECS[i].shr);
            chk($sformatf("R13 vec%0d completion", i), int'(timeout), 0);
            chk($sformatf("R6 R7 vec%0d bus op", i), int'(got_op), int'(VECS[i].exp_op));
            chk($sformatf("R12 vec%0d writeback", i), int'(got_wb), int'(VECS[i].exp_wb));
            chk($sformatf("R6 R7 vec%0d stall until grant", i), int'(early), 0);
            if (VECS[i].exp_wb)
               chk($sformatf("R12 vec%0d wb addr", i), int'(got_wbaddr), int'(VECS[i].exp_wbaddr));
         end
      end

      // R4: write hit on Modified completes in the request cycle
      run_cpu(1'b1, 8'h52, 1'b0);
      chk("R4 silent write bus op", int'(got_op), 0);
      run_snoop(2'd1, 8'h52);
      chk("R4 line stays dirty", int'(got_flush), 1);

      // R1: mid-run reset clears every line
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      run_snoop(2'd1, 8'h52);
      chk("R1 shared after second reset", int'(got_shared), 0);
      run_snoop(2'd1, 8'h03);
      chk("R1 flush after second reset", int'(got_flush), 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule